// File: doc/BRIEF.md
# Two-Wire Fast Byte Transmitter

This block is the sending side of a fast byte transfer on a shared serial bus. The bus has three open-collector lines: clock, data and attention. A local producer hands over one byte and a flag that marks it as the final byte of a stream. The block then releases the clock line to tell the host it is ready. It waits for the host's single start signal, which is the host releasing the data line. The byte then goes out in four timed slots, two bits per slot, one bit on the data wire and one on the clock wire. No handshake is made for each bit.

After the fourth slot the block shows a status pattern. For a byte that is not the last, data is released and clock is pulled, and the block waits for the host to pull data as an acknowledge. For the final byte, data is pulled and clock is released. That pattern is held for a fixed time, with no wait on the host, and the block then returns to idle. If the host asserts attention at any point while a byte is in flight, the byte is dropped and a one-cycle abort pulse hands control to the attention service.

Slot spacing and the end-of-data hold are counted in ticks of a 1 MHz timebase. The line outputs are pull enables: 1 pulls the line low. The line inputs read 1 when the line is active, meaning some device pulls it low.

Top module: `fastTxTop`

## Requirements
- R1: After reset, byteReady=1, busy=0, clkPull=1, dataPull=0 and atnAbort=0.
- R2: byteValid sampled high while byteReady=1 captures byteData and byteLast. From the next cycle byteReady=0, busy=1, clkPull=0 and dataPull=0. A byteValid while busy has no effect on the byte sent.
- R3: While the data line reads active (busDataIn=1) after a load, the block keeps both lines released and stays busy. The transfer starts on the clock edge where busDataIn reads 0.
- R4: Slot k (k=0..3) drives dataPull = NOT bit(2k+1) and clkPull = NOT bit(2k). The order is bits 1/0, then 3/2, then 5/4, then 7/6. A bit of 1 therefore leaves its line released.
- R5: The first slot starts on the cycle after the start is seen. Each slot then lasts exactly SLOT_US ticks, counting the ticks sampled after that slot begins.
- R6: After the fourth slot of a byte whose last flag is 0, dataPull=0 and clkPull=1 while busy. This holds until busDataIn reads 1. The next cycle is idle with byteReady=1.
- R7: After the fourth slot of a byte whose last flag is 1, dataPull=1 and clkPull=0 for exactly EOI_US ticks, whatever busDataIn reads. The block then returns to idle, with clkPull=1 and dataPull=0.
- R8: busAtnIn=1 in any busy state ends the transfer. In the next cycle busy=0, the idle line pattern is back and atnAbort=1 for exactly one cycle. busAtnIn has no effect while idle.
- R9: busy stays high from the load until the acknowledge, the end of the end-of-data hold, or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick1us | input | 1 | One-cycle pulse every microsecond |
| byteValid | input | 1 | Producer offers a byte |
| byteData | input | 8 | Byte to send |
| byteLast | input | 1 | Byte is the final one of the stream |
| byteReady | output | 1 | Block can accept a byte |
| busy | output | 1 | A byte is in flight |
| busDataIn | input | 1 | Data line reads active |
| busAtnIn | input | 1 | Attention line reads active |
| dataPull | output | 1 | Pull the data line low |
| clkPull | output | 1 | Pull the clock line low |
| atnAbort | output | 1 | One-cycle pulse when attention aborts a byte |

## Verification
The embedded properties check several things on every cycle. The start is taken only from the release state when data reads inactive and attention is quiet. The slot timer stays within its bound, and a slot's line pair never changes while its slot index holds. The acknowledge wait does not exit early. Attention in any busy state ends in idle with a single abort pulse. The bench scenarios are needed for the rest: the actual bit-to-wire mapping for varied bytes, the exact tick at which each slot and the end-of-data hold end, and the fact that a second byteValid while busy leaves the byte on the wires unchanged.

// File: rtl/fastTxPkg.sv
package fastTxPkg;
  localparam int BYTE_W     = 8;
  localparam int SLOT_CNT   = BYTE_W / 2;
  localparam int SLOT_IDX_W = $clog2(SLOT_CNT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_SLOT,
    ST_ACK,
    ST_EOI
  } txState_e;

  typedef enum logic [2:0] {
    DRV_IDLE,
    DRV_RELEASE,
    DRV_SLOT,
    DRV_ACK,
    DRV_EOI
  } drive_e;

  typedef struct packed {
    logic                  loadByte;
    drive_e                drive;
    logic [SLOT_IDX_W-1:0] slotIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/fastTxCtrl.sv
module fastTxCtrl
  import fastTxPkg::*;
#(
  parameter int SLOT_US = 10,
  parameter int EOI_US  = 33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick1us,
  input  logic        byteValid,
  input  logic        lastFlag,
  input  logic        busDataIn,
  input  logic        busAtnIn,
  output ctrlStrobe_t ctrl,
  output logic        byteReady,
  output logic        busy,
  output logic        atnAbort
);
  localparam int TMR_MAX = (SLOT_US > EOI_US) ? SLOT_US : EOI_US;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  txState_e              state;
  logic [TMR_W-1:0]      tmr;
  logic [SLOT_IDX_W-1:0] slotIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      slotIdx  <= '0;
      atnAbort <= 1'b0;
    end else begin
      atnAbort <= 1'b0;
      if (state != ST_IDLE && busAtnIn) begin
        state    <= ST_IDLE;
        atnAbort <= 1'b1;
        tmr      <= '0;
        slotIdx  <= '0;
      end else begin
        case (state)
          ST_IDLE: if (byteValid) state <= ST_READY;
          ST_READY: begin
            if (!busDataIn) begin
              state   <= ST_SLOT;
              tmr     <= '0;
              slotIdx <= '0;
            end
          end
          ST_SLOT: begin
            if (tick1us) begin
              if (tmr == TMR_W'(SLOT_US - 1)) begin
                tmr <= '0;
                if (slotIdx == SLOT_IDX_W'(SLOT_CNT - 1)) begin
                  state <= lastFlag ? ST_EOI : ST_ACK;
                end else begin
                  slotIdx <= slotIdx + 1'b1;
                end
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          ST_ACK: if (busDataIn) state <= ST_IDLE;
          ST_EOI: begin
            if (tick1us) begin
              if (tmr == TMR_W'(EOI_US - 1)) begin
                state <= ST_IDLE;
                tmr   <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    byteReady     = (state == ST_IDLE);
    busy          = !byteReady;
    ctrl.loadByte = byteReady && byteValid;
    ctrl.slotIdx  = slotIdx;
    case (state)
      ST_READY: ctrl.drive = DRV_RELEASE;
      ST_SLOT:  ctrl.drive = DRV_SLOT;
      ST_ACK:   ctrl.drive = DRV_ACK;
      ST_EOI:   ctrl.drive = DRV_EOI;
      default:  ctrl.drive = DRV_IDLE;
    endcase
  end

  // R3: start leaves the release state only on inactive data
  a_r3_start_on_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && !busDataIn && !busAtnIn) |=> (state == ST_SLOT && slotIdx == '0));

  a_r3_hold_while_data: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && busDataIn && !busAtnIn) |=> state == ST_READY);

  // R5: slot timer bound
  a_r5_tmr_bound: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SLOT |-> tmr < TMR_W'(SLOT_US));

  // R6: acknowledge wait does not end early
  a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && !busDataIn && !busAtnIn) |=> state == ST_ACK);

  // R8: attention aborts from any busy state
  a_r8_atn_abort: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busAtnIn) |=> (atnAbort && byteReady));

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    atnAbort |=> !atnAbort);

  // R9: busy holds through load, release and slots
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !busAtnIn && (state == ST_READY || state == ST_SLOT)) |=> busy);
endmodule

// File: rtl/fastTxDatapath.sv
module fastTxDatapath
  import fastTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteLast,
  output logic              lastFlag,
  output logic              dataPull,
  output logic              clkPull
);
  logic [BYTE_W-1:0] byteReg;
  logic [1:0]        slotPair [SLOT_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= '0;
      lastFlag <= 1'b0;
    end else if (ctrl.loadByte) begin
      byteReg  <= byteData;
      lastFlag <= byteLast;
    end
  end

  // Inverted pair per slot: upper bit of pair goes to data, lower to clock
  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_pair
    assign slotPair[g] = ~byteReg[2*g +: 2];
  end

  always_comb begin
    case (ctrl.drive)
      DRV_RELEASE: {dataPull, clkPull} = 2'b00;
      DRV_SLOT:    {dataPull, clkPull} = slotPair[ctrl.slotIdx];
      DRV_ACK:     {dataPull, clkPull} = 2'b01;
      DRV_EOI:     {dataPull, clkPull} = 2'b10;
      default:     {dataPull, clkPull} = 2'b01;
    endcase
  end

  // R4: a pair stays put for the whole of its slot
  a_r4_slot_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.drive == DRV_SLOT && $past(ctrl.drive == DRV_SLOT) && $stable(ctrl.slotIdx))
      |-> $stable({dataPull, clkPull}));

  // R2: the held byte does not change while a transfer is running
  a_r2_byte_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.drive != DRV_IDLE && $past(ctrl.drive != DRV_IDLE)) |-> $stable(byteReg));
endmodule

// File: rtl/fastTxTop.sv
module fastTxTop
  import fastTxPkg::*;
#(
  parameter int SLOT_US = 10,
  parameter int EOI_US  = 33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick1us,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        byteLast,
  output logic        byteReady,
  output logic        busy,
  input  logic        busDataIn,
  input  logic        busAtnIn,
  output logic        dataPull,
  output logic        clkPull,
  output logic        atnAbort
);
  ctrlStrobe_t ctrl;
  logic        lastFlag;

  fastTxCtrl #(.SLOT_US(SLOT_US), .EOI_US(EOI_US)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .byteValid(byteValid),
    .lastFlag(lastFlag), .busDataIn(busDataIn), .busAtnIn(busAtnIn),
    .ctrl(ctrl), .byteReady(byteReady), .busy(busy), .atnAbort(atnAbort)
  );

  fastTxDatapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteData(byteData),
    .byteLast(byteLast), .lastFlag(lastFlag), .dataPull(dataPull), .clkPull(clkPull)
  );

  // R8: an abort pulse always lands on the idle line pattern
  a_r8_abort_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    atnAbort |-> (clkPull && !dataPull && !busy));
endmodule

// File: tb/fastTxTop_tb_top.sv
module fastTxTop_tb_top;
  localparam int SLOT_US = 10;
  localparam int EOI_US  = 33;
  localparam int TICK_DIV = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1us = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteLast = 1'b0;
  logic byteReady, busy, dataPull, clkPull, atnAbort;
  logic hostData = 1'b0;
  logic busAtnIn = 1'b0;
  logic busDataIn;
  int tests = 0;
  int fails = 0;
  int divCnt = 0;

  assign busDataIn = hostData | dataPull;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    divCnt  <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    tick1us <= (divCnt == TICK_DIV - 1);
  end

  fastTxTop #(.SLOT_US(SLOT_US), .EOI_US(EOI_US)) dut_i (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .byteReady(byteReady), .busy(busy),
    .busDataIn(busDataIn), .busAtnIn(busAtnIn), .dataPull(dataPull),
    .clkPull(clkPull), .atnAbort(atnAbort)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expPair(input logic [7:0] b, input int k);
    return {~b[2*k+1], ~b[2*k]};
  endfunction

  function automatic logic [1:0] expEnd(input logic last);
    return last ? 2'b10 : 2'b01;
  endfunction

  task automatic waitTicks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick1us) c++;
    end
  endtask

  // checks the abort that follows raising attention at a negedge
  task automatic doAbort(input string tag);
    busAtnIn = 1'b1;
    @(negedge clk);
    busAtnIn = 1'b0;
    chk(tag, {4'b0, atnAbort, busy, clkPull, dataPull}, 8'b0000_1010);
    @(negedge clk);
    chk(tag, {7'b0, atnAbort}, 8'h00);
  endtask

  // atnAt: -1 none, 0 while released, 1 in slot 2, 2 in acknowledge wait
  task automatic sendByte(input logic [7:0] b, input logic last, input int atnAt);
    int acc;
    @(negedge clk);
    hostData  = 1'b1;
    byteData  = b;
    byteLast  = last;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk("R2 load", {4'b0, byteReady, busy, clkPull, dataPull}, 8'b0000_0100);
    byteData  = ~b;
    byteLast  = ~last;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3 hold released", {5'b0, busy, clkPull, dataPull}, 8'b0000_0100);
    if (atnAt == 0) begin
      doAbort("R8 abort released");
      return;
    end
    hostData = 1'b0;
    @(posedge clk);
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      waitTicks(10 * k + SLOT_US - 1 - acc);
      acc = 10 * k + SLOT_US - 1;
      @(negedge clk);
      chk($sformatf("R4 slot%0d", k), {6'b0, dataPull, clkPull}, {6'b0, expPair(b, k)});
      if (atnAt == 1 && k == 2) begin
        doAbort("R8 abort slot");
        return;
      end
      waitTicks(1);
      acc++;
      @(negedge clk);
      if (k < 3)
        chk($sformatf("R5 edge slot%0d", k + 1), {6'b0, dataPull, clkPull}, {6'b0, expPair(b, k + 1)});
      else
        chk("R5 end pattern", {6'b0, dataPull, clkPull}, {6'b0, expEnd(last)});
    end
    if (last) begin
      waitTicks(EOI_US - 1);
      @(negedge clk);
      chk("R7 eoi held", {5'b0, busy, dataPull, clkPull}, 8'b0000_0110);
      waitTicks(1);
      @(negedge clk);
      chk("R7 eoi done", {5'b0, byteReady, clkPull, dataPull}, 8'b0000_0110);
    end else begin
      repeat (40) @(negedge clk);
      chk("R6 ack wait", {5'b0, busy, dataPull, clkPull}, 8'b0000_0101);
      if (atnAt == 2) begin
        doAbort("R8 abort ack");
        return;
      end
      hostData = 1'b1;
      @(negedge clk);
      chk("R6 ack done R9", {5'b0, byteReady, busy, clkPull}, 8'b0000_0101);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset", {4'b0, byteReady, busy, clkPull, dataPull}, 8'b0000_1010);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {7'b0, atnAbort}, 8'h00);
    busAtnIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAtnIn = 1'b0;
    chk("R8 idle atn ignored", {4'b0, byteReady, atnAbort, clkPull, dataPull}, 8'b0000_1010);
    sendByte(8'h00, 1'b0, -1);
    sendByte(8'hFF, 1'b0, -1);
    sendByte(8'hA5, 1'b1, -1);
    sendByte(8'h3C, 1'b0, 0);
    sendByte(8'h96, 1'b0, 1);
    sendByte(8'h5A, 1'b0, 2);
    for (int i = 0; i < 8; i++) begin
      sendByte(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), -1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule